// File: doc/BRIEF.md
# MDIO Management Master

This block is a two-wire station management master. It reads and writes 16-bit registers in external Ethernet PHYs over a clock line (MDC) and one bidirectional data line. The data line appears at the block edge as three signals: a driven value, an output enable and a sampled input. An external pad joins them.

A host starts a transaction with a one-cycle start pulse. The same cycle carries a read/write flag, a 5-bit PHY address, a 5-bit register address and, for a write, 16 bits of data. The block raises busy and sends one 64-bit management frame. For a read, it leaves the data line to the PHY for the turnaround and data bits. At the end of the frame it pulses done for one cycle. On a read, the received word appears on the read-data bus and stays there until the next read completes.

MDC is derived from the system clock by a half-period divider. The divider value is checked when the design is built, against the minimum phase length and the minimum period. MDC runs only while a frame is in flight and is held low at all other times.

Top module: `mdio_master`

## Requirements
- R1: After reset and whenever no frame is in flight, mdc is 0, mdio_oe is 0, busy is 0 and done is 0.
- R2: During a frame, each MDC low phase and each MDC high phase lasts exactly HALF_DIV system clocks. The first low phase starts at the clock edge that accepts start. The build fails if HALF_DIV clocks are shorter than 160 ns or two half-periods are shorter than 400 ns at SYS_CLK_HZ.
- R3: A frame is 64 bits, sent most significant bit first, one bit per MDC period, in this order: 32 ones, start code 01, opcode (01 for write, 10 for read), phy_addr, reg_addr, 2 turnaround bits, 16 data bits.
- R4: A write (rw = 0) drives turnaround as 10, then wr_data, and keeps mdio_oe at 1 for all 64 bits.
- R5: A read (rw = 1) drives mdio_oe to 1 for bits 0 to 45 and to 0 from bit 46 through bit 63.
- R6: mdio_out and mdio_oe change only at a falling MDC edge or at frame start. Both stay constant while mdc is 1.
- R7: On a read, mdio_in is sampled at the rising MDC edge of each of bits 48 to 63. The first sample is the MSB of rd_data.
- R8: At the falling MDC edge after bit 63, busy drops and done is 1 for exactly one cycle. On a read, rd_data is updated in that same cycle. A write leaves rd_data unchanged.
- R9: A start pulse while busy is 1 is ignored. The frame in flight continues unchanged and no extra frame follows.
- R10: One frame has exactly 64 MDC rising edges and lasts 128 × HALF_DIV system clocks from the accepting edge to done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle transaction request |
| rw | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Data for a write |
| rd_data | output | 16 | Last word read |
| busy | output | 1 | Frame in flight |
| done | output | 1 | One-cycle end-of-frame pulse |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data line value when driven |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_in | input | 1 | Data line as seen at the pad |

## Verification
The bench compares every output against a model indexed by clocks since acceptance, so an MDC off by one clock or a data bit moved to the wrong edge shows up in the exact cycle. The PHY model drives its bits only during the read window. A master that released the line late, or sampled on the falling edge, returns a shifted or corrupted word. Writes followed by reads of the same address catch a wrong turnaround code or a swapped address field. A start pulse in the middle of a frame shows whether the lockout works: a design without it restarts the frame or runs a second one.

// File: rtl/mdio_pkg.sv
// Shared constants, opcode encoding and frame assembly for the MDIO master.
// Assumes a 64-bit frame sent MSB first, one bit per MDC period.
package mdio_pkg;
    localparam int FRAME_BITS = 64;
    localparam int DRIVE_END  = 46;   // first bit index the PHY owns on a read
    localparam int DATA_FIRST = 48;   // first data bit index

    typedef enum logic [1:0] {
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } mdio_op_e;

    // Assemble the outgoing frame; read frames carry filler where the PHY drives
    function automatic logic [FRAME_BITS-1:0] build_frame(
        input logic        is_read,
        input logic [4:0]  phy,
        input logic [4:0]  regad,
        input logic [15:0] wdata
    );
        mdio_op_e op;
        op = is_read ? OP_READ : OP_WRITE;
        return {32'hFFFF_FFFF, 2'b01, op, phy, regad,
                is_read ? 2'b11 : 2'b10,
                is_read ? 16'h0000 : wdata};
    endfunction
endpackage

// File: rtl/mdio_clkgen.sv
// MDC generator: while run is high, toggles mdc every HALF_DIV system clocks,
// starting low. Emits one-cycle strobes at the clock edge that makes mdc rise
// or fall. Assumes HALF_DIV >= 1. Holds mdc low while run is low.
module mdio_clkgen #(
    parameter int HALF_DIV = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int CW = $clog2(HALF_DIV + 1);

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = run && (cnt == CW'(HALF_DIV - 1));
    assign rise = tick && !mdc;
    assign fall = tick && mdc;

    // Half-period counter and MDC toggle
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_seq.sv
// Frame sequencer: loads a frame on an accepted start, shifts one bit per
// falling-edge strobe, captures read data on rising-edge strobes and closes the
// frame after bit 63. Assumes rise/fall strobes come from mdio_clkgen.
module mdio_seq
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        rw,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wr_data,
    input  logic        rise,
    input  logic        fall,
    input  logic        mdio_in,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        mdio_out,
    output logic        mdio_oe
);
    localparam int IW = $clog2(FRAME_BITS);

    logic [FRAME_BITS-1:0] shreg;
    logic [IW-1:0]         bit_idx;
    logic                  is_read;
    logic [15:0]           cap;

    assign mdio_oe  = busy && (!is_read || (bit_idx < IW'(DRIVE_END)));
    assign mdio_out = mdio_oe && shreg[FRAME_BITS-1];

    // Frame state: accept, shift and finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            is_read <= 1'b0;
            bit_idx <= '0;
            shreg   <= '0;
            rd_data <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy    <= 1'b1;
                    is_read <= rw;
                    bit_idx <= '0;
                    shreg   <= build_frame(rw, phy_addr, reg_addr, wr_data);
                end
            end else if (fall) begin
                if (bit_idx == IW'(FRAME_BITS - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    if (is_read) rd_data <= cap;
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                    shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
                end
            end
        end
    end

    // Read capture on the rising MDC edge of each data bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap <= '0;
        end else if (busy && rise && (bit_idx >= IW'(DATA_FIRST))) begin
            cap <= {cap[14:0], mdio_in};
        end
    end
endmodule

// File: rtl/mdio_master.sv
// MDIO management master top: joins the MDC generator and frame sequencer and
// checks at build time that HALF_DIV meets the MDC timing limits.
// Assumes an external pad combines mdio_out/mdio_oe/mdio_in.
module mdio_master #(
    parameter int SYS_CLK_HZ = 100_000_000,
    parameter int HALF_DIV   = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        rw,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    output logic        busy,
    output logic        done,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    localparam longint unsigned HALF_SCALED = 64'(HALF_DIV) * 64'd1_000_000_000;
    localparam longint unsigned PHASE_LIMIT = 64'(SYS_CLK_HZ) * 64'd160;
    localparam longint unsigned PERIOD_LIM  = 64'(SYS_CLK_HZ) * 64'd400;

    generate
        if (HALF_DIV < 1 || HALF_SCALED < PHASE_LIMIT || 2 * HALF_SCALED < PERIOD_LIM) begin : g_bad_div
            $error("mdio_master: HALF_DIV too small for MDC timing limits");
        end
    endgenerate

    logic rise, fall;

    mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .mdc  (mdc),
        .rise (rise),
        .fall (fall)
    );

    mdio_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .rw      (rw),
        .phy_addr(phy_addr),
        .reg_addr(reg_addr),
        .wr_data (wr_data),
        .rise    (rise),
        .fall    (fall),
        .mdio_in (mdio_in),
        .busy    (busy),
        .done    (done),
        .rd_data (rd_data),
        .mdio_out(mdio_out),
        .mdio_oe (mdio_oe)
    );
endmodule

// File: rtl/mdio_master_chk.sv
// Checker for mdio_master: bus idle state, phase length, data stability while
// MDC is high, done pulse shape and start lockout. Bound into every instance.
module mdio_master_chk #(
    parameter int HALF_DIV = 20
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic mdc,
    input logic mdio_out,
    input logic mdio_oe
);
    logic [15:0] hi_cnt;

    // Count cycles MDC has been high
    always_ff @(posedge clk) begin
        if (!rst_n) hi_cnt <= '0;
        else        hi_cnt <= mdc ? hi_cnt + 1'b1 : 16'd0;
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    // R2
    high_phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdc) |-> (hi_cnt == 16'(HALF_DIV)));

    // R6
    data_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_out) && $stable(mdio_oe)));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy) && !mdc));

    // R9
    start_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !mdc) |=> busy);
endmodule

bind mdio_master mdio_master_chk #(.HALF_DIV(HALF_DIV)) u_chk (.*);

// File: tb/mdio_master_bench.sv
// Bench: per-clock reference model indexed by clocks since acceptance, plus a
// behavioural PHY with a 32x32 register file.
module mdio_master_bench;
    localparam int H  = 20;
    localparam int FR = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, rw = 1'b0;
    logic [4:0]  phy_addr = '0, reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        busy, done, mdc, mdio_out, mdio_oe;
    logic        mdio_in = 1'b1;

    int checks = 0, errors = 0;

    mdio_master #(.SYS_CLK_HZ(100_000_000), .HALF_DIV(H)) u_mdio_master (.*);

    always #5 clk = ~clk;

    logic [15:0] rf [0:31][0:31];
    bit          m_active = 0, pend = 0;
    int          n = 0;
    logic        m_rd, p_rw;
    logic [4:0]  m_phy, m_reg, p_phy, p_reg;
    logic [15:0] m_wd, p_wd, last_rd = '0;
    logic [63:0] m_frame;
    int          rises = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // Reference model and PHY, evaluated mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            int b;
            bit eb, ed, em, eo;
            if (pend && !m_active) begin
                m_active = 1; n = 0; rises = 0;
                m_rd = p_rw; m_phy = p_phy; m_reg = p_reg; m_wd = p_wd;
                m_frame = {32'hFFFF_FFFF, 2'b01, p_rw ? 2'b10 : 2'b01, p_phy, p_reg,
                           p_rw ? 2'b11 : 2'b10, p_rw ? 16'h0 : p_wd};
            end else if (m_active) begin
                n++;
            end
            if (m_active) begin
                b  = n / (2 * H);
                eb = n < FR * 2 * H;
                ed = n == FR * 2 * H;
                em = eb && ((n / H) % 2 == 1);
                eo = eb && (!m_rd || b < 46);
                if (em && ((n % H) == 0)) rises++;
                chk(busy == eb, "R10 busy", busy, eb);
                chk(done == ed, "R8 done", done, ed);
                chk(mdc == em, "R2 mdc", mdc, em);
                chk(mdio_oe == eo, m_rd ? "R5 oe" : "R4 oe", mdio_oe, eo);
                if (eo) chk(mdio_out == m_frame[63-b], b < 46 ? "R3 bit" : "R4 bit", mdio_out, m_frame[63-b]);
                if (ed) begin
                    m_active = 0;
                    chk(rises == FR, "R10 rises", rises, FR);
                    if (m_rd) begin
                        chk(rd_data == rf[m_phy][m_reg], "R7 rd_data", rd_data, rf[m_phy][m_reg]);
                        last_rd = rf[m_phy][m_reg];
                    end else begin
                        chk(rd_data == last_rd, "R8 rd_data kept", rd_data, last_rd);
                        rf[m_phy][m_reg] = m_wd;
                    end
                end
                if (m_active && m_rd && b >= 47) mdio_in = (b == 47) ? 1'b0 : rf[m_phy][m_reg][63-b];
                else mdio_in = 1'b1;
            end else begin
                chk(!busy && !done && !mdc && !mdio_oe, "R1 idle", {busy, done, mdc, mdio_oe}, 0);
                chk(rd_data == last_rd, "R8 rd_data held", rd_data, last_rd);
                mdio_in = 1'b1;
            end
            pend = start; p_rw = rw; p_phy = phy_addr; p_reg = reg_addr; p_wd = wr_data;
        end
    end

    task automatic pulse(input logic r, input logic [4:0] p, input logic [4:0] g, input logic [15:0] d);
        @(posedge clk); #1;
        start = 1; rw = r; phy_addr = p; reg_addr = g; wr_data = d;
        @(posedge clk); #1;
        start = 0; rw = ~r; phy_addr = ~p; reg_addr = ~g; wr_data = ~d;
    endtask

    task automatic xact(input logic r, input logic [4:0] p, input logic [4:0] g, input logic [15:0] d);
        pulse(r, p, g, d);
        @(negedge clk);
        while (m_active) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 32; i++)
            for (int j = 0; j < 32; j++)
                rf[i][j] = {i[4:0], j[4:0], 6'h2B} ^ 16'h5A00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(!busy && !done && !mdc && !mdio_oe && rd_data == 0, "R1 reset", {busy, done, mdc, mdio_oe}, 0);
        xact(1, 5'd3, 5'd2, 16'h0);
        xact(0, 5'd3, 5'd2, 16'hA5A5);
        xact(1, 5'd3, 5'd2, 16'h0);
        xact(1, 5'd31, 5'd31, 16'h0);
        xact(0, 5'd0, 5'd0, 16'hFFFF);
        xact(1, 5'd0, 5'd0, 16'h0);
        xact(0, 5'd17, 5'd10, 16'h0001);
        xact(1, 5'd17, 5'd10, 16'h0);
        // R9: second start mid-frame must be ignored
        pulse(1, 5'd9, 5'd4, 16'h0);
        repeat (300) @(posedge clk);
        pulse(0, 5'd22, 5'd7, 16'h1234);
        @(negedge clk);
        while (m_active) @(negedge clk);
        repeat (2 * H * 3) @(negedge clk);
        chk(rf[22][7] != 16'h1234, "R9 no extra write", rf[22][7], 16'h1234);
        xact(1, 5'd22, 5'd7, 16'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule